// File: doc/BRIEF.md
# Re-Arbitration Point Detector

This block sits beside the arbiter of one slave port on an AHB-style interconnect. Each cycle it looks at the transfer type, the burst kind and the ready signal, and it raises `arb_point` in any cycle where the arbiter may hand the slave to another master without breaking a burst in the middle of a beat. Five situations qualify: the port is idle; a single transfer completes; a fixed-length burst completes its last beat; an undefined-length incrementing burst crosses a selectable beat boundary; or a slot timer shows that the current master has held the slave too long.

The split boundary for undefined-length bursts is selected by `incr_split`, taken from the current master's settings. The slot timer limit comes from `slot_limit`. The strobe is decoded in the same cycle from the bus inputs and two small registered trackers: a beat counter and a slot down-counter. It is only ever high on a cycle with `hready` high. The arbiter takes the point on the same clock edge as the completing beat.

Top module: `rearb_point_detect`

## Requirements
- R1: In any cycle with `hready` high and `htrans` = IDLE (2'b00), `arb_point` is high.
- R2: A completing NONSEQ (2'b10) beat with `hburst` = SINGLE (3'b000) raises `arb_point`.
- R3: For fixed bursts (`hburst` 3'b010/3'b011 = 4 beats, 3'b100/3'b101 = 8 beats, 3'b110/3'b111 = 16 beats), `arb_point` is high on the completing beat whose number since the NONSEQ is a multiple of the burst length, i.e. the last beat.
- R4: For `hburst` = INCR (3'b001) with `incr_split` = 1, 2 or 3, `arb_point` is high on completing beats numbered 4k, 8k or 16k respectively, counted from the NONSEQ beat as beat 1.
- R5: With `incr_split` = 0, an INCR burst is never split by its beat count, however long it runs.
- R6: A completing NONSEQ beat loads the slot counter with `slot_limit`, and the counter then drops by one every clock. Once it has reached zero, the next completing SEQ (2'b11) beat raises `arb_point` and reloads the counter from `slot_limit`. An IDLE cycle with `hready` high clears it.
- R7: A `slot_limit` of zero, when loaded, disables the slot check until the next load.
- R8: `arb_point` is low whenever `hready` is low, and on BUSY (2'b01) cycles, which do not count as beats.
- R9: Only completing beats advance the beat count, and every completing NONSEQ beat restarts the count at 1. The count is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| htrans | input | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| hburst | input | 3 | Burst kind of the current transfer |
| hready | input | 1 | High when the current beat completes |
| incr_split | input | 2 | INCR split mode: 0 none, 1 four, 2 eight, 3 sixteen beats |
| slot_limit | input | SLOT_W | Slot timer reload value; 0 disables |
| arb_point | output | 1 | High in a cycle where re-arbitration is allowed |

## Verification
`arb_point` is a same-cycle function of the present inputs and of counters that were updated at earlier edges. A stimulus therefore shows its effect on the strobe in its own cycle, and on the counters from the following cycle. The bench drives each input set just after a falling edge and samples the strobe one time unit later, well before the rising edge. It then advances its own reference counters to mirror that edge. Slot expiry lands on the first completing SEQ beat at least `slot_limit`+1 cycles after the load, and the directed slot case checks that exact cycle.

// File: rtl/rearb_pkg.sv
package rearb_pkg;
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] BURST_SINGLE = 3'b000;
    localparam logic [2:0] BURST_INCR   = 3'b001;

    // 16 is the longest boundary; every boundary divides it, so a
    // count modulo 16 decides all of them
    localparam int MAX_BOUNDARY = 16;
    localparam int BEAT_W       = $clog2(MAX_BOUNDARY);
endpackage

// File: rtl/rearb_beat_tracker.sv
module rearb_beat_tracker
    import rearb_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             first_beat,
    input  logic             idle_done,
    output logic [CNT_W-1:0] beat_num
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } beat_st_t;

    beat_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        beat_num = first_beat ? CNT_W'(1) : st_q.cnt + CNT_W'(1);
        if (beat) begin
            st_d.cnt = beat_num;
        end else if (idle_done) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // a completing NONSEQ beat always restarts the count at one
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && first_beat) |=> (st_q.cnt == CNT_W'(1)));

    // stalled cycles do not move the count
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!beat && !idle_done) |=> $stable(st_q.cnt));
endmodule

// File: rtl/rearb_boundary.sv
module rearb_boundary
    import rearb_pkg::*;
#(
    parameter int CNT_W = BEAT_W
) (
    input  logic [2:0]       hburst,
    input  logic [1:0]       incr_split,
    input  logic [CNT_W-1:0] beat_num,
    output logic             hit
);
    logic [1:0]       size_code;
    logic [CNT_W-1:0] mask;

    always_comb begin
        // size_code 1/2/3 selects a 4/8/16 beat boundary, 0 none
        size_code = (hburst == BURST_INCR) ? incr_split : hburst[2:1];
        mask      = CNT_W'((32'd2 << size_code) - 32'd1);
        hit       = (size_code != 2'd0) && ((beat_num & mask) == '0);
    end
endmodule

// File: rtl/rearb_slot_timer.sv
module rearb_slot_timer
    import rearb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seq_beat,
    input  logic              idle_done,
    input  logic [SLOT_W-1:0] limit,
    output logic              expire_pt
);
    typedef struct packed {
        logic              armed;
        logic [SLOT_W-1:0] cnt;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        expire_pt = st_q.armed && (st_q.cnt == '0) && seq_beat;
        if (idle_done) begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end else if (start || expire_pt) begin
            st_d.armed = (limit != '0);
            st_d.cnt   = limit;
        end else if (st_q.armed && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - SLOT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_slot_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !idle_done && (limit != '0))
        |=> (st_q.armed && (st_q.cnt == $past(limit))));

    p_slot_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && (st_q.cnt != '0) && !start && !idle_done)
        |=> (st_q.cnt == $past(st_q.cnt) - SLOT_W'(1)));

    p_slot_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !idle_done && (limit == '0)) |=> !st_q.armed);
endmodule

// File: rtl/rearb_point_detect.sv
module rearb_point_detect
    import rearb_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        htrans,
    input  logic [2:0]        hburst,
    input  logic              hready,
    input  logic [1:0]        incr_split,
    input  logic [SLOT_W-1:0] slot_limit,
    output logic              arb_point
);
    logic              completing;
    logic              first_beat;
    logic              seq_beat;
    logic              idle_done;
    logic [BEAT_W-1:0] beat_num;
    logic              bnd_hit;
    logic              slot_hit;

    always_comb begin
        completing = hready && htrans[1];
        first_beat = completing && (htrans == TR_NONSEQ);
        seq_beat   = completing && (htrans == TR_SEQ);
        idle_done  = hready && (htrans == TR_IDLE);
    end

    rearb_beat_tracker #(.CNT_W(BEAT_W)) u_beats (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat       (completing),
        .first_beat (first_beat),
        .idle_done  (idle_done),
        .beat_num   (beat_num)
    );

    rearb_boundary #(.CNT_W(BEAT_W)) u_bound (
        .hburst     (hburst),
        .incr_split (incr_split),
        .beat_num   (beat_num),
        .hit        (bnd_hit)
    );

    rearb_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (first_beat),
        .seq_beat  (seq_beat),
        .idle_done (idle_done),
        .limit     (slot_limit),
        .expire_pt (slot_hit)
    );

    always_comb begin
        arb_point = idle_done
                 || (completing && ((hburst == BURST_SINGLE) || bnd_hit || slot_hit));
    end

    p_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hready || (htrans == TR_BUSY)) |-> !arb_point);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (htrans == TR_IDLE)) |-> arb_point);

    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hready && (htrans == TR_NONSEQ) && (hburst == BURST_SINGLE)) |-> arb_point);
endmodule

// File: tb/rearb_point_detect_tb.sv
module rearb_point_detect_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic [2:0] hburst = 3'b000;
    logic       hready = 1'b1;
    logic [1:0] incr_split = 2'd0;
    logic [7:0] slot_limit = 8'd0;
    logic       arb_point;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int m_beats = 0;
    int m_slot = 0;
    bit m_armed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rearb_point_detect #(.SLOT_W(8)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .htrans     (htrans),
        .hburst     (hburst),
        .hready     (hready),
        .incr_split (incr_split),
        .slot_limit (slot_limit),
        .arb_point  (arb_point)
    );

    function automatic int burst_len(input logic [2:0] hb);
        case (hb[2:1])
            2'd1:    return 4;
            2'd2:    return 8;
            2'd3:    return 16;
            default: return 0;
        endcase
    endfunction

    task automatic step(input logic [1:0] tr, input logic [2:0] hb, input logic rdy,
                        input logic [1:0] sp, input logic [7:0] lim, input string ptag);
        bit    beat, slot_hit, fix_hit, incr_hit, expv;
        int    n, div;
        string tag;
        htrans = tr; hburst = hb; hready = rdy; incr_split = sp; slot_limit = lim;
        #1;
        beat     = rdy && tr[1];
        n        = (tr == 2'b10) ? 1 : m_beats + 1;
        slot_hit = beat && (tr == 2'b11) && m_armed && (m_slot == 0);
        fix_hit  = (hb > 3'd1) && (n % burst_len(hb) == 0);
        div      = (sp == 2'd1) ? 4 : (sp == 2'd2) ? 8 : 16;
        incr_hit = (hb == 3'd1) && (sp != 2'd0) && (n % div == 0);
        expv     = (rdy && tr == 2'b00) || (beat && (hb == 3'd0 || fix_hit || incr_hit || slot_hit));
        if (!rdy || tr == 2'b01)  tag = "R8";
        else if (tr == 2'b00)     tag = "R1";
        else if (hb == 3'd0)      tag = "R2";
        else if (slot_hit)        tag = "R6";
        else if (hb == 3'd1)      tag = (sp == 2'd0) ? "R5" : "R4";
        else                      tag = "R3";
        checks++;
        if (arb_point !== expv) begin
            failures++;
            $display("FAIL %s %s: arb_point=%0b expected=%0b (htrans=%0d hburst=%0d beat=%0d)",
                     tag, ptag, arb_point, expv, tr, hb, n);
        end
        if (beat) m_beats = n;
        else if (rdy && tr == 2'b00) m_beats = 0;
        if (rdy && tr == 2'b00) begin
            m_armed = 0; m_slot = 0;
        end else if ((beat && tr == 2'b10) || slot_hit) begin
            m_armed = (lim != 0); m_slot = lim;
        end else if (m_armed && m_slot > 0) begin
            m_slot--;
        end
        @(negedge clk);
    endtask

    task automatic burst(input logic [2:0] hb, input int nbeats, input logic [1:0] sp,
                         input logic [7:0] lim, input bit noisy, input string ptag);
        for (int i = 0; i < nbeats; i++) begin
            logic [1:0] tr;
            tr = (i == 0) ? 2'b10 : 2'b11;
            if (noisy && i > 0 && ($urandom % 6) == 0) step(2'b01, hb, 1'b1, sp, lim, ptag);
            while (noisy && ($urandom % 4) == 0) step(tr, hb, 1'b0, sp, lim, ptag);
            step(tr, hb, 1'b1, sp, lim, ptag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state: count starts at zero, slot timer disarmed (R9, R7)
        for (int i = 0; i < 4; i++) step(2'b11, 3'd1, 1'b1, 2'd1, 8'd0, "R9 reset");
        step(2'b00, 3'd0, 1'b1, 2'd0, 8'd0, "R1 idle");
        burst(3'd0, 1, 2'd0, 8'd0, 1'b0, "R2 single");
        burst(3'd5, 8, 2'd0, 8'd0, 1'b1, "R3 incr8 stalls");
        burst(3'd6, 16, 2'd0, 8'd0, 1'b0, "R3 wrap16");
        burst(3'd1, 9, 2'd1, 8'd0, 1'b0, "R4 split4");
        burst(3'd1, 17, 2'd3, 8'd0, 1'b0, "R4 split16");
        burst(3'd1, 20, 2'd0, 8'd0, 1'b0, "R5 R7 unbroken");
        burst(3'd1, 12, 2'd0, 8'd3, 1'b0, "R6 slot3");
        // slot expired during a stall: fires on the completing SEQ beat
        step(2'b10, 3'd1, 1'b1, 2'd0, 8'd1, "R6 load");
        step(2'b11, 3'd1, 1'b0, 2'd0, 8'd1, "R6 stall");
        step(2'b11, 3'd1, 1'b0, 2'd0, 8'd1, "R6 stall");
        step(2'b11, 3'd1, 1'b1, 2'd0, 8'd1, "R6 expire");
        burst(3'd1, 3, 2'd1, 8'd0, 1'b0, "R9 pre");
        burst(3'd1, 4, 2'd1, 8'd0, 1'b0, "R9 restart");
        step(2'b01, 3'd1, 1'b1, 2'd1, 8'd0, "R8 busy");
        step(2'b00, 3'd0, 1'b0, 2'd0, 8'd0, "R8 idle wait");
        for (int b = 0; b < 300; b++) begin
            logic [2:0] hb;
            int         len;
            hb  = 3'($urandom % 8);
            len = (hb == 3'd0) ? 1 : (hb == 3'd1) ? 1 + int'($urandom % 40) : burst_len(hb);
            burst(hb, len, 2'($urandom % 4),
                  (($urandom % 3) == 0) ? 8'd0 : 8'($urandom % 12), 1'b1, "rand");
            for (int g = 0; g < int'($urandom % 3); g++)
                step(2'b00, 3'd0, 1'($urandom % 2), 2'd0, 8'd0, "rand gap");
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule